// File: doc/BRIEF.md
# Word-Gated Router Input Buffer and Link Stage

This block is one input port of an on-chip network router, together with the register stage that drives a link. Each incoming flit carries a 2-bit kind, a virtual-channel bit and a 4-bit lane mask, with one mask bit for each 32-bit word lane of the 128-bit payload. Flits are queued per virtual channel. The storage is built as four separate banks, each one word wide. A bank is written only when its lane is marked valid, so unused words cause no write activity.

On the read side, the caller names a virtual channel and pops its oldest flit into the link register. Each lane of that register has its own load enable. A lane that the popped flit marks invalid keeps the word it already held, so its wires do not toggle. The effect matches a flit that repeats the previous word in that position, but the flit never has to be re-encoded.

Head and single-flit packets use only lanes 0 and 1. The block clears lanes 2 and 3 of their mask on entry, whatever mask the sender supplied. The pointer logic of each queue is an ordinary circular FIFO that does not depend on the lane mask.

Top module: `lane_gated_port`

## Requirements
- R1: After reset every virtual channel reports empty and not full, `outValid` is 0, `outData` and `outMask` are zero, and both error outputs are 0.
- R2: A flit whose kind is head (2'b00) or single (2'b11) has mask bits 3 and 2 forced to 0. Its lanes 2 and 3 are never written, and `outMask[3:2]` is 0 when such a flit is presented.
- R3: In the cycle after a pop, and in any cycle with no pop, every lane k of `outData` (bits 32k+31..32k) whose bit in the popped mask is 0 keeps its previous value.
- R4: A pop requested while `rdEn` is 1 and `rdVc` is not empty appears on the link one clock later. `outValid` is 1, and `outVc`, `outKind` and `outMask` are those of the oldest flit of that channel. The lanes marked valid carry that flit's words, and flits leave each channel in arrival order.
- R5: Each of the 2 virtual channels holds up to 4 flits independently. `full[v]` and `empty[v]` reflect the occupancy of channel v after the most recent clock edge.
- R6: A write to a full channel is dropped, leaving the stored contents unchanged, and `errWrFull` is 1 for exactly the following cycle.
- R7: A read from an empty channel is dropped, `outValid` is 0 in the following cycle, and `errRdEmpty` is 1 for exactly that cycle.
- R8: A write and a pop in the same cycle on the same non-full, non-empty channel both take effect, leaving the occupancy unchanged. The pointers wrap past the last slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Flit present on the input |
| inVc | input | 1 | Virtual channel of the input flit |
| inKind | input | 2 | Flit kind: 00 head, 01 body, 10 tail, 11 single |
| inMask | input | 4 | Valid bit for each word lane |
| inData | input | 128 | Four 32-bit word lanes, lane k at bits 32k+31..32k |
| rdEn | input | 1 | Pop request |
| rdVc | input | 1 | Virtual channel to pop |
| full | output | 2 | Full flag for each channel |
| empty | output | 2 | Empty flag for each channel |
| errWrFull | output | 1 | Previous cycle wrote to a full channel |
| errRdEmpty | output | 1 | Previous cycle popped an empty channel |
| outValid | output | 1 | Link register holds a newly popped flit |
| outVc | output | 1 | Channel of the presented flit |
| outKind | output | 2 | Kind of the presented flit |
| outMask | output | 4 | Lane mask of the presented flit |
| outData | output | 128 | Link word lanes |

## Verification
A wrong pointer or count inside the block shows at the ports within a few cycles. The full and empty flags go wrong on the next edge. Words from an older or newer slot then reach `outData` one cycle after the next pop of that channel.

A lane gate that is stuck open has two visible effects. Junk words written on invalid input lanes appear on the link, and an invalid output lane changes value. Either one is seen in the cycle right after the pop that carried it.

A mishandled head or single mask leaks lanes 2 and 3 into `outMask` and `outData` in that same cycle.

// File: rtl/lgp_pkg.sv
package lgp_pkg;
  parameter int NUM_VC = 2;
  parameter int DEPTH  = 4;
  parameter int WORD_W = 32;
  parameter int LANES  = 4;

  localparam int VC_W    = (NUM_VC > 1) ? $clog2(NUM_VC) : 1;
  localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int ADDR_W  = VC_W + PTR_W;
  localparam int ENTRIES = NUM_VC * DEPTH;
  localparam int CNT_W   = PTR_W + 1;
  localparam int DATA_W  = WORD_W * LANES;
  localparam logic [LANES-1:0] HEAD_LANES = LANES'(2'b11);

  typedef enum logic [1:0] {
    FT_HEAD   = 2'b00,
    FT_BODY   = 2'b01,
    FT_TAIL   = 2'b10,
    FT_SINGLE = 2'b11
  } flitKind_t;

  typedef struct packed {
    logic              push;
    logic [ADDR_W-1:0] pushAddr;
    logic              pop;
    logic [ADDR_W-1:0] popAddr;
  } bufStrobe_t;
endpackage

// File: rtl/lgp_ctrl.sv
module lgp_ctrl
  import lgp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [VC_W-1:0]   inVc,
  input  logic              rdEn,
  input  logic [VC_W-1:0]   rdVc,
  output bufStrobe_t        str,
  output logic [NUM_VC-1:0] full,
  output logic [NUM_VC-1:0] empty,
  output logic              errWrFull,
  output logic              errRdEmpty
);
  logic [CNT_W-1:0] count [NUM_VC];
  logic [PTR_W-1:0] wPtr  [NUM_VC];
  logic [PTR_W-1:0] rPtr  [NUM_VC];
  logic pushOk, popOk;

  always_comb begin
    pushOk       = inValid && !full[inVc];
    popOk        = rdEn && !empty[rdVc];
    str.push     = pushOk;
    str.pushAddr = {inVc, wPtr[inVc]};
    str.pop      = popOk;
    str.popAddr  = {rdVc, rPtr[rdVc]};
  end

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    logic pushHit, popHit;
    assign pushHit  = pushOk && (inVc == VC_W'(v));
    assign popHit   = popOk && (rdVc == VC_W'(v));
    assign full[v]  = (count[v] == CNT_W'(DEPTH));
    assign empty[v] = (count[v] == '0);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        count[v] <= '0;
        wPtr[v]  <= '0;
        rPtr[v]  <= '0;
      end else begin
        if (pushHit)
          wPtr[v] <= (wPtr[v] == PTR_W'(DEPTH - 1)) ? '0 : wPtr[v] + 1'b1;
        if (popHit)
          rPtr[v] <= (rPtr[v] == PTR_W'(DEPTH - 1)) ? '0 : rPtr[v] + 1'b1;
        if (pushHit && !popHit)
          count[v] <= count[v] + 1'b1;
        else if (popHit && !pushHit)
          count[v] <= count[v] - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errWrFull  <= 1'b0;
      errRdEmpty <= 1'b0;
    end else begin
      errWrFull  <= inValid && full[inVc];
      errRdEmpty <= rdEn && empty[rdVc];
    end
  end
endmodule

// File: rtl/lgp_datapath.sv
module lgp_datapath
  import lgp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  bufStrobe_t        str,
  input  logic [1:0]        inKind,
  input  logic [LANES-1:0]  inMask,
  input  logic [DATA_W-1:0] inData,
  input  logic [VC_W-1:0]   rdVc,
  output logic              outValid,
  output logic [VC_W-1:0]   outVc,
  output logic [1:0]        outKind,
  output logic [LANES-1:0]  outMask,
  output logic [DATA_W-1:0] outData
);
  logic [LANES-1:0] effMask;
  logic [1:0]       kindMem [ENTRIES];
  logic [LANES-1:0] maskMem [ENTRIES];
  logic [LANES-1:0] popMask;

  always_comb begin
    if (inKind == FT_HEAD || inKind == FT_SINGLE)
      effMask = inMask & HEAD_LANES;
    else
      effMask = inMask;
  end

  assign popMask = maskMem[str.popAddr];

  always_ff @(posedge clk) begin
    if (str.push) begin
      kindMem[str.pushAddr] <= inKind;
      maskMem[str.pushAddr] <= effMask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outVc    <= '0;
      outKind  <= '0;
      outMask  <= '0;
    end else begin
      outValid <= str.pop;
      if (str.pop) begin
        outVc   <= rdVc;
        outKind <= kindMem[str.popAddr];
        outMask <= popMask;
      end
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [WORD_W-1:0] bank [ENTRIES];
    logic [WORD_W-1:0] linkWord;

    always_ff @(posedge clk) begin
      if (str.push && effMask[k])
        bank[str.pushAddr] <= inData[k*WORD_W +: WORD_W];
    end

    always_ff @(posedge clk) begin
      if (!rstN)
        linkWord <= '0;
      else if (str.pop && popMask[k])
        linkWord <= bank[str.popAddr];
    end

    assign outData[k*WORD_W +: WORD_W] = linkWord;
  end
endmodule

// File: rtl/lane_gated_port.sv
module lane_gated_port
  import lgp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [VC_W-1:0]   inVc,
  input  logic [1:0]        inKind,
  input  logic [LANES-1:0]  inMask,
  input  logic [DATA_W-1:0] inData,
  input  logic              rdEn,
  input  logic [VC_W-1:0]   rdVc,
  output logic [NUM_VC-1:0] full,
  output logic [NUM_VC-1:0] empty,
  output logic              errWrFull,
  output logic              errRdEmpty,
  output logic              outValid,
  output logic [VC_W-1:0]   outVc,
  output logic [1:0]        outKind,
  output logic [LANES-1:0]  outMask,
  output logic [DATA_W-1:0] outData
);
  bufStrobe_t str;

  lgp_ctrl u_ctrl (
    .clk, .rstN, .inValid, .inVc, .rdEn, .rdVc,
    .str, .full, .empty, .errWrFull, .errRdEmpty
  );

  lgp_datapath u_dp (
    .clk, .rstN, .str, .inKind, .inMask, .inData, .rdVc,
    .outValid, .outVc, .outKind, .outMask, .outData
  );
endmodule

// File: rtl/lgp_checker.sv
module lgp_checker
  import lgp_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [VC_W-1:0]   inVc,
  input logic              rdEn,
  input logic [VC_W-1:0]   rdVc,
  input logic [NUM_VC-1:0] full,
  input logic [NUM_VC-1:0] empty,
  input logic              errWrFull,
  input logic              errRdEmpty,
  input logic              outValid,
  input logic [1:0]        outKind,
  input logic [LANES-1:0]  outMask,
  input logic [DATA_W-1:0] outData
);
  AST_HEAD_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    outValid && (outKind == FT_HEAD || outKind == FT_SINGLE) |-> outMask[LANES-1:2] == '0); // R2

  AST_IDLE_LINK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    rstN && !(rdEn && !empty[rdVc]) |=> $stable(outData)); // R3

  for (genvar k = 0; k < LANES; k++) begin : g_chk
    AST_LANE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      outValid && !outMask[k] && $past(rstN) |-> $stable(outData[k*WORD_W +: WORD_W])); // R3
  end

  AST_POP_VISIBLE: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && !empty[rdVc] |=> outValid); // R4

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    (full & empty) == '0); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    inValid && full[inVc] |=> errWrFull); // R6

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && empty[rdVc] |=> errRdEmpty && !outValid); // R7
endmodule

bind lane_gated_port lgp_checker u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inVc(inVc), .rdEn(rdEn), .rdVc(rdVc),
  .full(full), .empty(empty), .errWrFull(errWrFull), .errRdEmpty(errRdEmpty),
  .outValid(outValid), .outKind(outKind), .outMask(outMask), .outData(outData)
);

// File: tb/tb_lane_gated_port.sv
module tb_lane_gated_port;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inVc = 1'b0, rdEn = 1'b0, rdVc = 1'b0;
  logic [1:0] inKind = 2'b00;
  logic [3:0] inMask = 4'h0;
  logic [127:0] inData = '0;
  logic [1:0] full, empty;
  logic errWrFull, errRdEmpty, outValid, outVc;
  logic [1:0] outKind;
  logic [3:0] outMask;
  logic [127:0] outData;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  typedef struct packed {logic [1:0] kind; logic [3:0] mask; logic [127:0] data;} ent_t;
  ent_t q0[$];
  ent_t q1[$];

  logic expValid = 0, expVc = 0, expErrW = 0, expErrR = 0;
  logic [1:0] expKind = 0;
  logic [3:0] expMask = 0;
  logic [127:0] expData = '0;

  always #10 clk = ~clk;

  lane_gated_port dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int qsize(input logic v);
    return v ? q1.size() : q0.size();
  endfunction

  task automatic compareAll();
    logic [1:0] eEmpty, eFull;
    eEmpty = {q1.size() == 0, q0.size() == 0};
    eFull  = {q1.size() == 4, q0.size() == 4};
    chk(empty == eEmpty, "R5", "empty", 128'(empty), 128'(eEmpty));
    chk(full == eFull, "R5", "full", 128'(full), 128'(eFull));
    chk(errWrFull == expErrW, "R6", "errWrFull", 128'(errWrFull), 128'(expErrW));
    chk(errRdEmpty == expErrR, "R7", "errRdEmpty", 128'(errRdEmpty), 128'(expErrR));
    chk(outValid == expValid, "R4", "outValid", 128'(outValid), 128'(expValid));
    chk(outData == expData, "R3", "outData", outData, expData);
    if (expValid) begin
      chk(outVc == expVc, "R4", "outVc", 128'(outVc), 128'(expVc));
      chk(outKind == expKind, "R4", "outKind", 128'(outKind), 128'(expKind));
      chk(outMask == expMask, "R2", "outMask", 128'(outMask), 128'(expMask));
    end
  endtask

  // One cycle: compare at negedge, drive, update model, advance
  task automatic step(input logic v, input logic vc, input logic [1:0] kind,
                      input logic [3:0] mask, input logic [127:0] data,
                      input logic rd, input logic rvc);
    bit pushOk, popOk;
    ent_t e;
    compareAll();
    inValid = v; inVc = vc; inKind = kind; inMask = mask; inData = data;
    rdEn = rd; rdVc = rvc;
    pushOk = v && qsize(vc) < 4;
    popOk  = rd && qsize(rvc) > 0;
    expErrW = v && !pushOk;
    expErrR = rd && !popOk;
    expValid = popOk;
    if (popOk) begin
      e = rvc ? q1.pop_front() : q0.pop_front();
      expVc = rvc; expKind = e.kind; expMask = e.mask;
      for (int k = 0; k < 4; k++)
        if (e.mask[k]) expData[k*32 +: 32] = e.data[k*32 +: 32];
    end
    if (pushOk) begin
      e.kind = kind;
      e.mask = (kind == 2'b00 || kind == 2'b11) ? (mask & 4'b0011) : mask;
      e.data = data;
      if (vc) q1.push_back(e); else q0.push_back(e);
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    chk(outValid == 0 && outData == '0 && outMask == 0, "R1", "link reset",
        outData, '0);
    chk(empty == 2'b11 && full == 2'b00 && !errWrFull && !errRdEmpty, "R1",
        "flags reset", 128'({empty, full, errWrFull, errRdEmpty}), 128'(6'b110000));
    // R7: pop from empty
    step(0, 0, 2'b01, 4'h0, '0, 1, 0);
    step(0, 0, 2'b01, 4'h0, '0, 1, 1);
    // R5/R6: fill channel 0, then overflow
    step(1, 0, 2'b00, 4'hF, rnd128(), 0, 0); // R2 head with upper lanes set
    step(1, 0, 2'b01, 4'h5, rnd128(), 0, 0);
    step(1, 0, 2'b01, 4'hA, rnd128(), 0, 0);
    step(1, 0, 2'b10, 4'hF, rnd128(), 0, 0);
    step(1, 0, 2'b01, 4'hF, rnd128(), 0, 0); // R6 dropped
    step(1, 1, 2'b11, 4'hF, rnd128(), 0, 0); // R5 other channel independent
    // drain both, then over-read
    for (int i = 0; i < 6; i++) step(0, 0, 2'b01, 4'h0, '0, 1, (i == 2) ? 1'b1 : 1'b0);
    // R8: simultaneous push/pop on same channel
    step(1, 1, 2'b01, 4'h3, rnd128(), 0, 1);
    for (int i = 0; i < 10; i++) step(1, 1, 2'b01, 4'(i), rnd128(), 1, 1);
    // Randomised traffic covering R2, R3, R4, R8
    for (int i = 0; i < 3000; i++)
      step($urandom_range(0, 99) < 55, 1'($urandom), 2'($urandom), 4'($urandom),
           rnd128(), $urandom_range(0, 99) < 50, 1'($urandom));
    for (int i = 0; i < 10; i++) step(0, 0, 2'b01, 4'h0, '0, 1, 1'(i));
    compareAll();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule